// File: doc/BRIEF.md
# Successive-Integration Conversion Sequencer

This block is the digital controller of an integrating analog-to-digital converter. A `start` request launches a conversion. The block drives one-hot switch-select outputs through a fixed order of phases: integrate, three de-integrate passes, and between those passes a settle (rest) phase and a residue-amplify (x10) phase.

During each de-integrate pass the block counts clocks until the comparator changes level. Each pass carries one tenth the weight of the pass before it, and the middle pass counts against the reading. From these counts the block forms a signed reading with one more decimal digit per pass.

The whole sequence then runs a second time with the inputs shorted, which measures the converter's own offset. That offset reading is subtracted from the input reading, and the corrected value is presented together with a one-clock `done` pulse. The analog integrator, the residue amplifier and any display logic sit outside this block.

Top module: `si_adc_seq`

## Requirements
- R1: The integrate phase (`ph_int`=1) lasts exactly INT_SHORT clocks when `range_lo` was 0 at the accepted start, and exactly INT_LONG clocks when it was 1. The range is latched at start.
- R2: Each pass runs its phases in this order: integrate, de-integrate 1, rest, x10, de-integrate 2, rest, x10, de-integrate 3. At most one of `ph_int`, `ph_deint`, `ph_rest`, `ph_x10` is high in any cycle.
- R3: Every rest phase lasts REST_LEN clocks and every x10 phase lasts AMP_LEN clocks.
- R4: `comp` is synchronised through two flops, and a change of the synchronised level ends a de-integrate pass. The pass count is the number of clocks spent in the pass before the edge on which the change is seen. A toggle of `comp` placed d clocks after the first cycle of the pass therefore yields a count of d+2. `ph_de_down` is high only during the second de-integrate pass.
- R5: A pass reading is 100·c1 − 10·c2 + c3, where c1, c2 and c3 are the counts of the three de-integrate passes.
- R6: `result` is the input-pass reading minus the shorted-pass reading, as a signed two's-complement value.
- R7: If no level change is seen within TMO_MULT·(integrate length) clocks, the de-integrate pass ends with that count, `overrange` is set, and the sequence continues. `overrange` is cleared by the next accepted start.
- R8: `done` is high for exactly one clock, in the first idle cycle after the final de-integrate pass. `result` changes only in that cycle and holds its value otherwise.
- R9: `start` is accepted only while idle. A start pulse during a conversion has no effect on the sequence or the result.
- R10: `ph_short` is high during every phase of the second pass and low otherwise.
- R11: After reset all phase outputs, `done`, `overrange` and `result` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a conversion (accepted when idle) |
| range_lo | input | 1 | 1 selects the long integrate length, 0 the short one |
| comp | input | 1 | Asynchronous comparator level |
| ph_int | output | 1 | Integrate switch select |
| ph_deint | output | 1 | De-integrate (reference) switch select |
| ph_de_down | output | 1 | Current de-integrate pass counts downward |
| ph_rest | output | 1 | Settle phase |
| ph_x10 | output | 1 | Residue amplify-and-invert phase |
| ph_short | output | 1 | Inputs shorted (offset pass) |
| done | output | 1 | One-clock completion pulse |
| overrange | output | 1 | A de-integrate pass timed out in the last conversion |
| result | output | 32 | Signed corrected reading |

## Verification
The bench builds the block with integrate lengths of 20 and 50 clocks, rest 3 and x10 4, so the timeouts become 40 and 100 clocks. With these values a full two-pass conversion, a timeout in any pass, and both range settings fit into a few hundred cycles each. The short windows also let comparator toggles land at zero, small and large offsets within a pass, which covers the first-cycle crossing and negative corrected readings.

// File: rtl/si_adc_pkg.sv
package si_adc_pkg;
  localparam int RES_W = 32;
  typedef logic signed [RES_W-1:0] reading_t;

  typedef enum logic [3:0] {
    PH_IDLE, PH_INT, PH_DE1, PH_REST1, PH_AMP1,
    PH_DE2, PH_REST2, PH_AMP2, PH_DE3
  } phase_e;

  localparam reading_t W_COARSE = 100;
  localparam reading_t W_MID    = 10;
  localparam reading_t W_FINE   = 1;

  // signed contribution of one de-integrate count to the pass reading
  function automatic reading_t pass_term(input logic [1:0] idx, input reading_t cnt);
    case (idx)
      2'd0:    return cnt * W_COARSE;
      2'd1:    return -(cnt * W_MID);
      default: return cnt * W_FINE;
    endcase
  endfunction

  // input reading corrected by the shorted-input reading
  function automatic reading_t offset_fix(input reading_t raw, input reading_t zero);
    return raw - zero;
  endfunction
endpackage

// File: rtl/si_cmp_sync.sv
module si_cmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic comp_in,
  output logic xing
);
  logic [STAGES-1:0] chain;
  logic              prev;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= comp_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b0;
        else     chain[i] <= chain[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= chain[STAGES-1];
  end

  assign xing = chain[STAGES-1] ^ prev;
endmodule

// File: rtl/si_seq_ctrl.sv
module si_seq_ctrl
  import si_adc_pkg::*;
#(
  parameter int INT_SHORT = 1000,
  parameter int INT_LONG  = 10000,
  parameter int REST_LEN  = 100,
  parameter int AMP_LEN   = 100,
  parameter int TMO_MULT  = 2,
  parameter int CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             range_lo,
  input  logic             xing,
  output phase_e           ph,
  output logic             pass,
  output logic             start_ok,
  output logic             de_end,
  output logic             tmo_hit,
  output logic [1:0]       de_idx,
  output logic [CNT_W-1:0] de_val
);
  logic [CNT_W-1:0] tcnt, int_len, tmo_len;
  logic             is_de;

  assign tmo_len  = int_len * CNT_W'(TMO_MULT);
  assign is_de    = (ph == PH_DE1) || (ph == PH_DE2) || (ph == PH_DE3);
  assign de_idx   = (ph == PH_DE1) ? 2'd0 : (ph == PH_DE2) ? 2'd1 : 2'd2;
  assign tmo_hit  = is_de && !xing && (tcnt == tmo_len - 1'b1);
  assign de_end   = is_de && (xing || tmo_hit);
  assign de_val   = xing ? tcnt : tmo_len;
  assign start_ok = (ph == PH_IDLE) && start;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= PH_IDLE;
      tcnt    <= '0;
      pass    <= 1'b0;
      int_len <= CNT_W'(INT_SHORT);
    end else begin
      case (ph)
        PH_IDLE: if (start_ok) begin
          ph      <= PH_INT;
          tcnt    <= '0;
          pass    <= 1'b0;
          int_len <= range_lo ? CNT_W'(INT_LONG) : CNT_W'(INT_SHORT);
        end
        PH_INT:
          if (tcnt == int_len - 1'b1) begin ph <= PH_DE1; tcnt <= '0; end
          else tcnt <= tcnt + 1'b1;
        PH_REST1, PH_REST2:
          if (tcnt == CNT_W'(REST_LEN - 1)) begin
            ph   <= (ph == PH_REST1) ? PH_AMP1 : PH_AMP2;
            tcnt <= '0;
          end else tcnt <= tcnt + 1'b1;
        PH_AMP1, PH_AMP2:
          if (tcnt == CNT_W'(AMP_LEN - 1)) begin
            ph   <= (ph == PH_AMP1) ? PH_DE2 : PH_DE3;
            tcnt <= '0;
          end else tcnt <= tcnt + 1'b1;
        PH_DE1, PH_DE2, PH_DE3:
          if (de_end) begin
            tcnt <= '0;
            if (ph == PH_DE1)      ph <= PH_REST1;
            else if (ph == PH_DE2) ph <= PH_REST2;
            else if (!pass) begin ph <= PH_INT; pass <= 1'b1; end
            else                   ph <= PH_IDLE;
          end else tcnt <= tcnt + 1'b1;
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/si_accum.sv
module si_accum
  import si_adc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             de_end,
  input  logic             tmo_hit,
  input  logic [1:0]       de_idx,
  input  logic [CNT_W-1:0] de_val,
  input  logic             pass,
  output reading_t         result,
  output logic             done,
  output logic             overrange
);
  reading_t acc, saved, nxt;

  assign nxt = acc + pass_term(de_idx, reading_t'(de_val));

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      saved     <= '0;
      result    <= '0;
      done      <= 1'b0;
      overrange <= 1'b0;
    end else begin
      done <= 1'b0;
      if (clear) begin
        acc       <= '0;
        overrange <= 1'b0;
      end else if (de_end) begin
        overrange <= overrange | tmo_hit;
        if (de_idx == 2'd2) begin
          acc <= '0;
          if (!pass) saved <= nxt;
          else begin
            result <= offset_fix(saved, nxt);
            done   <= 1'b1;
          end
        end else acc <= nxt;
      end
    end
  end
endmodule

// File: rtl/si_adc_seq.sv
module si_adc_seq
  import si_adc_pkg::*;
#(
  parameter int INT_SHORT = 1000,
  parameter int INT_LONG  = 10000,
  parameter int REST_LEN  = 100,
  parameter int AMP_LEN   = 100,
  parameter int TMO_MULT  = 2,
  parameter int SYNC_FF   = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic                    range_lo,
  input  logic                    comp,
  output logic                    ph_int,
  output logic                    ph_deint,
  output logic                    ph_de_down,
  output logic                    ph_rest,
  output logic                    ph_x10,
  output logic                    ph_short,
  output logic                    done,
  output logic                    overrange,
  output logic signed [RES_W-1:0] result
);
  localparam int MAX_TMO = TMO_MULT * INT_LONG;
  localparam int MAX_PH  = (REST_LEN > AMP_LEN) ? REST_LEN : AMP_LEN;
  localparam int MAX_CNT = (MAX_TMO > MAX_PH) ? MAX_TMO : MAX_PH;
  localparam int CNT_W   = $clog2(MAX_CNT + 1) + 1;

  phase_e           ph;
  logic             pass, start_ok, de_end, tmo_hit, xing_w;
  logic [1:0]       de_idx;
  logic [CNT_W-1:0] de_val;

  si_cmp_sync #(.STAGES(SYNC_FF)) u_sync (
    .clk(clk), .rst(rst), .comp_in(comp), .xing(xing_w)
  );

  si_seq_ctrl #(
    .INT_SHORT(INT_SHORT), .INT_LONG(INT_LONG), .REST_LEN(REST_LEN),
    .AMP_LEN(AMP_LEN), .TMO_MULT(TMO_MULT), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .range_lo(range_lo), .xing(xing_w),
    .ph(ph), .pass(pass), .start_ok(start_ok), .de_end(de_end),
    .tmo_hit(tmo_hit), .de_idx(de_idx), .de_val(de_val)
  );

  si_accum #(.CNT_W(CNT_W)) u_acc (
    .clk(clk), .rst(rst), .clear(start_ok), .de_end(de_end), .tmo_hit(tmo_hit),
    .de_idx(de_idx), .de_val(de_val), .pass(pass),
    .result(result), .done(done), .overrange(overrange)
  );

  assign ph_int     = (ph == PH_INT);
  assign ph_deint   = (ph == PH_DE1) || (ph == PH_DE2) || (ph == PH_DE3);
  assign ph_de_down = (ph == PH_DE2);
  assign ph_rest    = (ph == PH_REST1) || (ph == PH_REST2);
  assign ph_x10     = (ph == PH_AMP1) || (ph == PH_AMP2);
  assign ph_short   = pass && (ph != PH_IDLE);
endmodule

// File: rtl/si_adc_chk.sv
module si_adc_chk
  import si_adc_pkg::*;
(
  input logic     clk,
  input logic     rst,
  input logic     start,
  input logic     ph_int,
  input logic     ph_deint,
  input logic     ph_de_down,
  input logic     ph_rest,
  input logic     ph_x10,
  input logic     ph_short,
  input logic     done,
  input logic     overrange,
  input reading_t result,
  input logic     xing
);
  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ph_int, ph_deint, ph_rest, ph_x10})); // R2
  AST_DOWN_IN_DE: assert property (@(posedge clk) disable iff (rst)
    ph_de_down |-> ph_deint); // R4
  AST_DE_ENDS_ON_XING: assert property (@(posedge clk) disable iff (rst)
    (ph_deint && xing) |=> !ph_deint); // R4
  AST_OVR_FROM_DE: assert property (@(posedge clk) disable iff (rst)
    $rose(overrange) |-> $past(ph_deint)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !(ph_int || ph_deint || ph_rest || ph_x10)); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result)); // R8
  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
    ($rose(ph_int) && !ph_short) |-> $past(start)); // R9
  AST_SHORT_BUSY: assert property (@(posedge clk) disable iff (rst)
    ph_short |-> (ph_int || ph_deint || ph_rest || ph_x10)); // R10
endmodule

bind si_adc_seq si_adc_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .ph_int(ph_int), .ph_deint(ph_deint),
  .ph_de_down(ph_de_down), .ph_rest(ph_rest), .ph_x10(ph_x10),
  .ph_short(ph_short), .done(done), .overrange(overrange), .result(result),
  .xing(xing_w)
);

// File: tb/tb_si_adc_seq.sv
`timescale 1ns/1ps
module tb_si_adc_seq;
  localparam int S = 20, L = 50, RL = 3, AL = 4;

  logic clk = 0, rst = 1, start = 0, range_lo = 0, comp = 0;
  logic ph_int, ph_deint, ph_de_down, ph_rest, ph_x10, ph_short, done, overrange;
  logic signed [31:0] result;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  si_adc_seq #(.INT_SHORT(S), .INT_LONG(L), .REST_LEN(RL), .AMP_LEN(AL)) dut (
    .clk(clk), .rst(rst), .start(start), .range_lo(range_lo), .comp(comp),
    .ph_int(ph_int), .ph_deint(ph_deint), .ph_de_down(ph_de_down),
    .ph_rest(ph_rest), .ph_x10(ph_x10), .ph_short(ph_short),
    .done(done), .overrange(overrange), .result(result));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference: phase 0 idle,1 int,2 de1,3 rest,4 x10,5 de2,6 rest,7 x10,8 de3
  int m_ph, m_t, m_pass, m_len, m_acc, m_saved, m_res, m_done, m_ovr;
  bit q1, q2, q3, xs;
  int lim;
  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_t = 0; m_pass = 0; m_len = S; m_acc = 0; m_saved = 0;
      m_res = 0; m_done = 0; m_ovr = 0; q1 = 0; q2 = 0; q3 = 0;
    end else begin
      xs = (q2 != q3); q3 = q2; q2 = q1; q1 = comp;
      m_done = 0;
      case (m_ph)
        0: if (start) begin
             m_ph = 1; m_t = 0; m_pass = 0; m_len = range_lo ? L : S;
             m_acc = 0; m_ovr = 0;
           end
        1, 3, 4, 6, 7: begin
          lim = (m_ph == 1) ? m_len : (m_ph == 3 || m_ph == 6) ? RL : AL;
          if (m_t == lim - 1) begin
            m_t = 0;
            m_ph = (m_ph == 1) ? 2 : (m_ph == 3) ? 4 : (m_ph == 4) ? 5 : (m_ph == 6) ? 7 : 8;
          end else m_t++;
        end
        default: begin
          if (xs || m_t == 2 * m_len - 1) begin
            if (!xs) m_ovr = 1;
            m_acc += ((m_ph == 2) ? 100 : (m_ph == 5) ? -10 : 1) * (xs ? m_t : 2 * m_len);
            m_t = 0;
            if (m_ph == 2) m_ph = 3;
            else if (m_ph == 5) m_ph = 6;
            else if (m_pass == 0) begin m_saved = m_acc; m_acc = 0; m_pass = 1; m_ph = 1; end
            else begin m_res = m_saved - m_acc; m_acc = 0; m_done = 1; m_ph = 0; end
          end else m_t++;
        end
      endcase
    end
  end

  // per-cycle comparison and phase run-length monitor
  int run_int = 0, run_rest = 0, run_x10 = 0, last_int = 0, last_rest = 0, last_x10 = 0;
  always @(negedge clk) begin
    if (!rst) begin
      chk(ph_int == (m_ph == 1), "R2 ph_int", ph_int, m_ph == 1);
      chk(ph_deint == (m_ph == 2 || m_ph == 5 || m_ph == 8), "R2 ph_deint", ph_deint, m_ph);
      chk(ph_rest == (m_ph == 3 || m_ph == 6), "R3 ph_rest", ph_rest, m_ph);
      chk(ph_x10 == (m_ph == 4 || m_ph == 7), "R3 ph_x10", ph_x10, m_ph);
      chk(ph_de_down == (m_ph == 5), "R4 ph_de_down", ph_de_down, m_ph == 5);
      chk(ph_short == (m_pass == 1 && m_ph != 0), "R10 ph_short", ph_short, m_pass);
      chk(done == m_done, "R8 done", done, m_done);
      chk(result == m_res, "R6 result", result, m_res);
      chk(overrange == m_ovr, "R7 overrange", overrange, m_ovr);
    end
    if (ph_int) run_int++; else if (run_int != 0) begin last_int = run_int; run_int = 0; end
    if (ph_rest) run_rest++; else if (run_rest != 0) begin last_rest = run_rest; run_rest = 0; end
    if (ph_x10) run_x10++; else if (run_x10 != 0) begin last_x10 = run_x10; run_x10 = 0; end
  end

  function automatic int reading(input int c1, input int c2, input int c3);
    return 100 * c1 - 10 * c2 + c3;
  endfunction

  // d[k] < 0: no comparator toggle in that pass (timeout)
  task automatic run_conv(input bit rng, input int d[6], input bit expect_ovr);
    int len = rng ? L : S;
    int c[6];
    int exp_res;
    for (int k = 0; k < 6; k++) c[k] = (d[k] < 0) ? 2 * len : d[k] + 2;
    exp_res = reading(c[0], c[1], c[2]) - reading(c[3], c[4], c[5]);
    @(negedge clk); start = 1; range_lo = rng;
    @(negedge clk); start = 0;
    for (int k = 0; k < 6; k++) begin
      while (!ph_deint) @(negedge clk);
      if (d[k] >= 0) begin
        repeat (d[k]) @(negedge clk);
        comp = ~comp;
      end
      while (ph_deint) @(negedge clk);
    end
    while (!done) @(negedge clk);
    chk(result == exp_res, "R5 R6 corrected reading", result, exp_res);
    chk(last_int == len, "R1 integrate length", last_int, len);
    chk(last_rest == RL, "R3 rest length", last_rest, RL);
    chk(last_x10 == AL, "R3 x10 length", last_x10, AL);
    chk(overrange == expect_ovr, "R7 overrange flag", overrange, expect_ovr);
    @(negedge clk);
    chk(done == 0, "R8 done one cycle", done, 0);
    chk(result == exp_res, "R8 result held", result, exp_res);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R11 reset state
    chk({ph_int, ph_deint, ph_de_down, ph_rest, ph_x10, ph_short, done, overrange} == 8'h0,
        "R11 controls at reset", {ph_int, ph_deint, ph_rest, ph_x10, done}, 0);
    chk(result == 0, "R11 result at reset", result, 0);
    rst = 0;
    repeat (3) @(negedge clk);
    chk(ph_int == 0 && done == 0, "R11 idle after reset", ph_int, 0);
    run_conv(0, '{5, 3, 7, 1, 2, 0}, 0);          // R1 short range, R4 counts d+2
    run_conv(1, '{60, 10, 0, 0, 0, 0}, 0);        // R1 long range
    run_conv(0, '{0, 0, 0, 9, 1, 1}, 0);          // R6 negative corrected result
    run_conv(0, '{-1, 4, 4, 0, 0, 0}, 1);         // R7 timeout in first pass
    run_conv(1, '{2, -1, 3, 1, 1, 1}, 1);         // R7 timeout in down-count pass
    run_conv(0, '{1, 1, 1, 1, 1, 1}, 0);          // R7 flag cleared by new start
    fork                                          // R9 start while busy is ignored
      begin repeat (30) @(negedge clk); start = 1; @(negedge clk); start = 0; end
    join_none
    run_conv(0, '{5, 3, 7, 1, 2, 0}, 0);
    repeat (10) @(negedge clk);
    chk(ph_int == 0 && ph_deint == 0, "R9 stays idle after stray start", ph_int, 0);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule